// File: doc/BRIEF.md
# Multi-Cache Ray Memory Interface

This block is the shared memory front end for a group of ray tracing units. Four read-only first-level caches sit inside it, one for each class of unit: traversal, list, intersection and ray generation/shading. Every unit of a class reaches memory through the single cache of that class. Each cache answers with data in the native width of its class. Misses go out over one 64-bit external read bus, which a round-robin arbiter shares among the four caches.

Each cache is direct-mapped with 16 lines. Line sizes differ by class. Traversal lines are 8 bytes and are read whole. List and shading units read 4-byte words, and their lines are 8 bytes wide so that a whole bus beat is kept. Intersection lines hold 36 bytes of triangle data, filled by five bus beats. The upper 4 bytes of the fifth beat are dropped. Memory is addressed in 8-byte beats. Each class owns a region selected by the top two address bits, and an intersection line n starts at beat 5n of its region.

Every unit port is a valid/ready pair on the request side and on the response side. A request is taken when `*_req_valid` and `*_req_ready` are both high on a clock edge. `*_req_ready` is high only while the cache holds no request. A response stays valid, with its data held stable, until `*_rsp_ready` is high on an edge. A miss stalls only its own port. The external command is valid/ready. Read beats arrive with `mem_rd_valid` and cannot be refused.

Top module: `rmi_top`

## Requirements
- R1: After reset, every `*_req_ready` is 1, every `*_rsp_valid` is 0, and `mem_cmd_valid` is 0.
- R2: A traversal read of line address A returns the 64-bit memory beat at beat address {2'd0, A}.
- R3: A list (class 1) or shading (class 3) read of word address W returns bits [31:0] of the beat at {class, W>>1} when W[0]=0, and bits [63:32] when W[0]=1.
- R4: An intersection read of line address A returns 288 bits. Bits [64k+63:64k] hold beat {2'd2, 5A+k} for k=0..3, and bits [287:256] hold bits [31:0] of beat {2'd2, 5A+4}.
- R5: A miss issues `mem_cmd_addr` = {class, line base beat} and `mem_cmd_len` = beats per line. The class codes are traversal=0, list=1, intersection=2, shading=3. The base beat is A for 8-byte lines and 5A for intersection lines. The length is 1 for 8-byte lines and 5 for intersection lines.
- R6: A hit raises `*_rsp_valid` in the first cycle after the request is taken, and issues no memory command.
- R7: A miss issues exactly one memory command and then returns the freshly filled data.
- R8: The caches are direct-mapped with 16 lines on line address bits [3:0]. A line with the same index but a different tag evicts the old one, so the old line misses again.
- R9: When several caches wait for the bus at once, commands are granted in round-robin order, starting with the class after the one last served.
- R10: A fill burst is never interrupted. No new command is accepted until every beat of the current burst has arrived, and each beat goes to the cache that owns the burst.
- R11: While `*_rsp_ready` is low, a valid response keeps `*_rsp_valid` high with unchanged data. A pending miss on one class does not delay hits on other classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trv_req_valid | input | 1 | Traversal request valid |
| trv_req_ready | output | 1 | Traversal request ready |
| trv_req_addr | input | AW | Traversal line address |
| trv_rsp_valid | output | 1 | Traversal response valid |
| trv_rsp_ready | input | 1 | Traversal response ready |
| trv_rsp_data | output | 64 | Traversal line data |
| lst_req_valid | input | 1 | List request valid |
| lst_req_ready | output | 1 | List request ready |
| lst_req_addr | input | AW+1 | List word address |
| lst_rsp_valid | output | 1 | List response valid |
| lst_rsp_ready | input | 1 | List response ready |
| lst_rsp_data | output | 32 | List word data |
| isc_req_valid | input | 1 | Intersection request valid |
| isc_req_ready | output | 1 | Intersection request ready |
| isc_req_addr | input | AW | Intersection line address |
| isc_rsp_valid | output | 1 | Intersection response valid |
| isc_rsp_ready | input | 1 | Intersection response ready |
| isc_rsp_data | output | 288 | Intersection triangle record |
| shd_req_valid | input | 1 | Shading request valid |
| shd_req_ready | output | 1 | Shading request ready |
| shd_req_addr | input | AW+1 | Shading word address |
| shd_rsp_valid | output | 1 | Shading response valid |
| shd_rsp_ready | input | 1 | Shading response ready |
| shd_rsp_data | output | 32 | Shading word data |
| mem_cmd_valid | output | 1 | Burst command valid |
| mem_cmd_ready | input | 1 | Burst command ready |
| mem_cmd_addr | output | AW+5 | Beat address {class, beat} |
| mem_cmd_len | output | 3 | Beats in the burst |
| mem_rd_valid | input | 1 | Read beat valid |
| mem_rd_data | input | 64 | Read beat data |

## Verification
A hit is due in the first cycle after the request is taken, so the bench counts cycles from the acceptance edge and expects a latency of exactly one sample. A miss has no fixed latency, because it depends on the arbiter and on the memory model. For a miss the bench waits for the response valid, then checks the data against beat values computed from the address. It also checks the command log kept by its memory model: the count, the address and the length of each command. All outputs are sampled on the falling clock edge, half a cycle after the registers that drive them change. Back-pressure is checked on every sample while the response is held, and the round-robin order is checked by the order of the logged commands.

// File: rtl/rmi_pkg.sv
package rmi_pkg;
  localparam int NCLS   = 4;
  localparam int BUS_W  = 64;
  localparam int LEN_W  = 3;
  typedef enum logic [1:0] {
    CLS_TRV = 2'd0,
    CLS_LST = 2'd1,
    CLS_ISC = 2'd2,
    CLS_SHD = 2'd3
  } cls_e;
endpackage

// File: rtl/rmi_cache.sv
module rmi_cache
  import rmi_pkg::*;
#(
  parameter int AW        = 10,
  parameter int LINES     = 16,
  parameter int BEATS     = 1,
  parameter int SUB       = 1,
  parameter int LINE_BITS = 64,
  parameter int CLS       = 0,
  parameter int IN_W      = AW + $clog2(SUB),
  parameter int RW        = LINE_BITS / SUB,
  parameter int CAW       = AW + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IN_W-1:0]   req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [RW-1:0]     resp_data,
  output logic              fill_req,
  output logic [CAW-1:0]    fill_addr,
  output logic [LEN_W-1:0]  fill_len,
  input  logic              fill_ack,
  input  logic              fill_beat,
  input  logic [BUS_W-1:0]  beat_data
);
  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - IDXW;
  localparam int SELB = $clog2(SUB);
  localparam int BW   = BUS_W * BEATS;
  localparam int BAW  = AW + 3;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FREQ, S_FILL} st_e;
  st_e st;

  logic [IN_W-1:0]      addr_q;
  logic [AW-1:0]        lad;
  logic [IDXW-1:0]      idx;
  logic [TAGW-1:0]      tag;
  logic [LINE_BITS-1:0] data_q [LINES];
  logic [TAGW-1:0]      tag_q  [LINES];
  logic [LINES-1:0]     vld_q;
  logic [LEN_W-1:0]     cnt;
  logic [BW-1:0]        fsr, full;
  logic                 hit, last_beat;
  logic [LINE_BITS-1:0] line_rd;

  assign lad       = AW'(addr_q >> SELB);
  assign idx       = lad[IDXW-1:0];
  assign tag       = lad[AW-1:IDXW];
  assign hit       = vld_q[idx] && (tag_q[idx] == tag);
  assign line_rd   = data_q[idx];
  assign last_beat = fill_beat && (cnt == LEN_W'(BEATS - 1));

  assign req_ready  = (st == S_IDLE);
  assign resp_valid = (st == S_LOOK) && hit;
  assign fill_req   = (st == S_FREQ);
  assign fill_addr  = {2'(CLS), BAW'(lad) * BAW'(BEATS)};
  assign fill_len   = LEN_W'(BEATS);

  always_comb begin
    full = fsr;
    full[(BEATS-1)*BUS_W +: BUS_W] = beat_data;
  end

  generate
    if (SUB > 1) begin : g_word
      logic [SELB-1:0] sel;
      assign sel       = addr_q[SELB-1:0];
      assign resp_data = line_rd[int'(sel)*RW +: RW];
    end else begin : g_line
      assign resp_data = line_rd[RW-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      cnt    <= '0;
      vld_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          st     <= S_LOOK;
        end
        S_LOOK: begin
          if (!hit)            st <= S_FREQ;
          else if (resp_ready) st <= S_IDLE;
        end
        S_FREQ: if (fill_ack) begin
          cnt <= '0;
          st  <= S_FILL;
        end
        default: if (fill_beat) begin
          cnt <= cnt + 1'b1;
          if (last_beat) begin
            vld_q[idx] <= 1'b1;
            st         <= S_LOOK;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && fill_beat) begin
      fsr[int'(cnt)*BUS_W +: BUS_W] <= beat_data;
      if (last_beat) begin
        data_q[idx] <= full[LINE_BITS-1:0];
        tag_q[idx]  <= tag;
      end
    end
  end

  p_hold_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data));
  p_one_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ack |=> !fill_req);
  p_beat_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_beat |-> st == S_FILL);
  p_ack_when_asked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ack |-> fill_req);
endmodule

// File: rtl/rmi_arb.sv
module rmi_arb
  import rmi_pkg::*;
#(
  parameter int N   = NCLS,
  parameter int CAW = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              fill_req,
  input  logic [N-1:0][CAW-1:0]     fill_addr,
  input  logic [N-1:0][LEN_W-1:0]   fill_len,
  output logic [N-1:0]              fill_ack,
  output logic [N-1:0]              fill_beat,
  output logic                      mem_cmd_valid,
  input  logic                      mem_cmd_ready,
  output logic [CAW-1:0]            mem_cmd_addr,
  output logic [LEN_W-1:0]          mem_cmd_len,
  input  logic                      mem_rd_valid
);
  localparam int OW = $clog2(N);

  logic [OW-1:0]    ptr, owner, pick;
  logic             busy, any;
  logic [LEN_W-1:0] left;
  int               j;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    j    = 0;
    for (int k = 0; k < N; k++) begin
      j = (int'(ptr) + k) % N;
      if (!any && fill_req[j]) begin
        any  = 1'b1;
        pick = OW'(j);
      end
    end
  end

  assign mem_cmd_valid = !busy && any;
  assign mem_cmd_addr  = fill_addr[pick];
  assign mem_cmd_len   = fill_len[pick];

  generate
    for (genvar g = 0; g < N; g++) begin : g_route
      assign fill_ack[g]  = mem_cmd_valid && mem_cmd_ready && (pick == OW'(g));
      assign fill_beat[g] = busy && mem_rd_valid && (owner == OW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ptr   <= '0;
      owner <= '0;
      left  <= '0;
    end else if (!busy) begin
      if (mem_cmd_valid && mem_cmd_ready) begin
        busy  <= 1'b1;
        owner <= pick;
        left  <= mem_cmd_len;
      end
    end else if (mem_rd_valid) begin
      left <= left - 1'b1;
      if (left == LEN_W'(1)) begin
        busy <= 1'b0;
        ptr  <= OW'((int'(owner) + 1) % N);
      end
    end
  end

  p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_ack));
  p_burst_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(mem_rd_valid && left == LEN_W'(1)) |=> busy && $stable(owner));
  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid);
  p_beats_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fill_beat) <= 1);
endmodule

// File: rtl/rmi_top.sv
module rmi_top
  import rmi_pkg::*;
#(
  parameter int AW    = 10,
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trv_req_valid,
  output logic             trv_req_ready,
  input  logic [AW-1:0]    trv_req_addr,
  output logic             trv_rsp_valid,
  input  logic             trv_rsp_ready,
  output logic [63:0]      trv_rsp_data,
  input  logic             lst_req_valid,
  output logic             lst_req_ready,
  input  logic [AW:0]      lst_req_addr,
  output logic             lst_rsp_valid,
  input  logic             lst_rsp_ready,
  output logic [31:0]      lst_rsp_data,
  input  logic             isc_req_valid,
  output logic             isc_req_ready,
  input  logic [AW-1:0]    isc_req_addr,
  output logic             isc_rsp_valid,
  input  logic             isc_rsp_ready,
  output logic [287:0]     isc_rsp_data,
  input  logic             shd_req_valid,
  output logic             shd_req_ready,
  input  logic [AW:0]      shd_req_addr,
  output logic             shd_rsp_valid,
  input  logic             shd_rsp_ready,
  output logic [31:0]      shd_rsp_data,
  output logic             mem_cmd_valid,
  input  logic             mem_cmd_ready,
  output logic [AW+4:0]    mem_cmd_addr,
  output logic [2:0]       mem_cmd_len,
  input  logic             mem_rd_valid,
  input  logic [63:0]      mem_rd_data
);
  localparam int CAW = AW + 5;

  logic [NCLS-1:0]            fr, ack, beat;
  logic [NCLS-1:0][CAW-1:0]   fa;
  logic [NCLS-1:0][LEN_W-1:0] fl;

  rmi_cache #(.AW(AW), .LINES(LINES), .BEATS(1), .SUB(1), .LINE_BITS(64),
              .CLS(int'(CLS_TRV))) i_trv (
    .clk, .rst_n,
    .req_valid(trv_req_valid), .req_ready(trv_req_ready), .req_addr(trv_req_addr),
    .resp_valid(trv_rsp_valid), .resp_ready(trv_rsp_ready), .resp_data(trv_rsp_data),
    .fill_req(fr[0]), .fill_addr(fa[0]), .fill_len(fl[0]), .fill_ack(ack[0]),
    .fill_beat(beat[0]), .beat_data(mem_rd_data));

  rmi_cache #(.AW(AW), .LINES(LINES), .BEATS(1), .SUB(2), .LINE_BITS(64),
              .CLS(int'(CLS_LST))) i_lst (
    .clk, .rst_n,
    .req_valid(lst_req_valid), .req_ready(lst_req_ready), .req_addr(lst_req_addr),
    .resp_valid(lst_rsp_valid), .resp_ready(lst_rsp_ready), .resp_data(lst_rsp_data),
    .fill_req(fr[1]), .fill_addr(fa[1]), .fill_len(fl[1]), .fill_ack(ack[1]),
    .fill_beat(beat[1]), .beat_data(mem_rd_data));

  rmi_cache #(.AW(AW), .LINES(LINES), .BEATS(5), .SUB(1), .LINE_BITS(288),
              .CLS(int'(CLS_ISC))) i_isc (
    .clk, .rst_n,
    .req_valid(isc_req_valid), .req_ready(isc_req_ready), .req_addr(isc_req_addr),
    .resp_valid(isc_rsp_valid), .resp_ready(isc_rsp_ready), .resp_data(isc_rsp_data),
    .fill_req(fr[2]), .fill_addr(fa[2]), .fill_len(fl[2]), .fill_ack(ack[2]),
    .fill_beat(beat[2]), .beat_data(mem_rd_data));

  rmi_cache #(.AW(AW), .LINES(LINES), .BEATS(1), .SUB(2), .LINE_BITS(64),
              .CLS(int'(CLS_SHD))) i_shd (
    .clk, .rst_n,
    .req_valid(shd_req_valid), .req_ready(shd_req_ready), .req_addr(shd_req_addr),
    .resp_valid(shd_rsp_valid), .resp_ready(shd_rsp_ready), .resp_data(shd_rsp_data),
    .fill_req(fr[3]), .fill_addr(fa[3]), .fill_len(fl[3]), .fill_ack(ack[3]),
    .fill_beat(beat[3]), .beat_data(mem_rd_data));

  rmi_arb #(.N(NCLS), .CAW(CAW)) i_arb (
    .clk, .rst_n,
    .fill_req(fr), .fill_addr(fa), .fill_len(fl),
    .fill_ack(ack), .fill_beat(beat),
    .mem_cmd_valid, .mem_cmd_ready, .mem_cmd_addr, .mem_cmd_len,
    .mem_rd_valid);
endmodule

// File: tb/test_rmi_top.sv
`timescale 1ns/1ps
module test_rmi_top;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         rq_v [4];
  logic [AW:0]  rq_a [4];
  logic         rs_r [4];
  logic         rq_rdy [4];
  logic         rs_v [4];
  logic [287:0] rs_d [4];
  logic [63:0]  trv_d;
  logic [31:0]  lst_d, shd_d;
  logic [287:0] isc_d;

  logic         mem_cmd_valid, mem_cmd_ready, mem_rd_valid;
  logic [AW+4:0] mem_cmd_addr;
  logic [2:0]   mem_cmd_len;
  logic [63:0]  mem_rd_data;

  rmi_top #(.AW(AW)) i_rmi_top (
    .clk, .rst_n,
    .trv_req_valid(rq_v[0]), .trv_req_ready(rq_rdy[0]), .trv_req_addr(rq_a[0][AW-1:0]),
    .trv_rsp_valid(rs_v[0]), .trv_rsp_ready(rs_r[0]), .trv_rsp_data(trv_d),
    .lst_req_valid(rq_v[1]), .lst_req_ready(rq_rdy[1]), .lst_req_addr(rq_a[1]),
    .lst_rsp_valid(rs_v[1]), .lst_rsp_ready(rs_r[1]), .lst_rsp_data(lst_d),
    .isc_req_valid(rq_v[2]), .isc_req_ready(rq_rdy[2]), .isc_req_addr(rq_a[2][AW-1:0]),
    .isc_rsp_valid(rs_v[2]), .isc_rsp_ready(rs_r[2]), .isc_rsp_data(isc_d),
    .shd_req_valid(rq_v[3]), .shd_req_ready(rq_rdy[3]), .shd_req_addr(rq_a[3]),
    .shd_rsp_valid(rs_v[3]), .shd_rsp_ready(rs_r[3]), .shd_rsp_data(shd_d),
    .mem_cmd_valid, .mem_cmd_ready, .mem_cmd_addr, .mem_cmd_len,
    .mem_rd_valid, .mem_rd_data);

  assign rs_d[0] = {224'b0, trv_d};
  assign rs_d[1] = {256'b0, lst_d};
  assign rs_d[2] = isc_d;
  assign rs_d[3] = {256'b0, shd_d};

  int checks = 0;
  int bad = 0;
  int ncmd = 0;
  int log_addr [512];
  int log_len  [512];

  function automatic logic [63:0] mw(input int b);
    return {32'(b) ^ 32'h5A00_0000, 32'(b) * 32'h9E37_79B1 + 32'h0000_1234};
  endfunction

  function automatic int beats_of(input int c);
    return (c == 2) ? 5 : 1;
  endfunction

  function automatic int sub_of(input int c);
    return (c == 1 || c == 3) ? 2 : 1;
  endfunction

  function automatic logic [287:0] expd(input int c, input int a);
    int base;
    logic [63:0] w;
    logic [319:0] t;
    base = c << (AW + 3);
    t = '0;
    if (c == 0) return {224'b0, mw(base + a)};
    if (c == 2) begin
      for (int k = 0; k < 5; k++) t[k*64 +: 64] = mw(base + 5*a + k);
      return t[287:0];
    end
    w = mw(base + (a >> 1));
    return {256'b0, (a % 2 == 1) ? w[63:32] : w[31:0]};
  endfunction

  function automatic string dreq(input int c);
    if (c == 0) return "R2";
    if (c == 2) return "R4";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [287:0] act, input logic [287:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // memory model: command accepted, two idle cycles, then beats back to back
  initial begin
    int mst, gap, bi, cur_a, cur_l;
    mst = 0; gap = 0; bi = 0; cur_a = 0; cur_l = 0;
    mem_cmd_ready = 1'b0;
    mem_rd_valid = 1'b0;
    mem_rd_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        case (mst)
          0: begin
            mem_rd_valid = 1'b0;
            mem_cmd_ready = 1'b1;
            if (mem_cmd_valid) begin
              cur_a = int'(mem_cmd_addr);
              cur_l = int'(mem_cmd_len);
              if (ncmd < 512) begin
                log_addr[ncmd] = cur_a;
                log_len[ncmd] = cur_l;
              end
              ncmd++;
              gap = 0;
              mst = 1;
            end
          end
          1: begin
            mem_cmd_ready = 1'b0;
            gap++;
            if (gap == 2) begin bi = 0; mst = 2; end
          end
          2: begin
            mem_rd_valid = 1'b1;
            mem_rd_data = mw(cur_a + bi);
            bi++;
            if (bi == cur_l) mst = 3;
          end
          default: begin
            mem_rd_valid = 1'b0;
            mst = 0;
          end
        endcase
      end
    end
  end

  task automatic access(input int c, input int a, input int hold,
                        output logic [287:0] d, output int lat);
    @(negedge clk);
    rq_v[c] = 1'b1;
    rq_a[c] = (AW+1)'(a);
    rs_r[c] = (hold == 0);
    while (!rq_rdy[c]) @(negedge clk);
    @(negedge clk);
    rq_v[c] = 1'b0;
    lat = 1;
    while (!rs_v[c]) begin
      @(negedge clk);
      lat++;
    end
    d = rs_d[c];
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rs_v[c] && rs_d[c] == d, "R11", "held response", rs_d[c], d);
    end
    rs_r[c] = 1'b1;
  endtask

  task automatic sweep(input int c);
    logic [287:0] d;
    int lat, n0, a, sb, nb;
    sb = sub_of(c);
    nb = beats_of(c);
    for (int l = 0; l < 20; l++) begin
      for (int s = 0; s < sb; s++) begin
        a = l * sb + s;
        n0 = ncmd;
        access(c, a, 0, d, lat);
        chk(d == expd(c, a), dreq(c), "read data", d, expd(c, a));
        if (s == 0) begin
          chk(ncmd == n0 + 1, "R7", "one command per miss", ncmd - n0, 1);
          chk(log_addr[ncmd-1] == (c << (AW+3)) + l * nb, "R5", "command address",
              log_addr[ncmd-1], (c << (AW+3)) + l * nb);
          chk(log_len[ncmd-1] == nb, "R5", "command length", log_len[ncmd-1], nb);
        end else begin
          chk(ncmd == n0 && lat == 1, "R6", "same-line word hit", lat, 1);
        end
      end
    end
    for (int l = 4; l < 20; l++) begin
      n0 = ncmd;
      access(c, l * sb, 0, d, lat);
      chk(ncmd == n0, "R6", "hit issues no command", ncmd - n0, 0);
      chk(lat == 1, "R6", "hit latency", lat, 1);
      chk(d == expd(c, l * sb), dreq(c), "hit data", d, expd(c, l * sb));
    end
    n0 = ncmd;
    access(c, 0, 0, d, lat);
    chk(ncmd == n0 + 1, "R8", "evicted line refetched", ncmd - n0, 1);
    chk(d == expd(c, 0), "R8", "refetched data", d, expd(c, 0));
    n0 = ncmd;
    access(c, 16 * sb, 0, d, lat);
    chk(ncmd == n0 + 1, "R8", "line 16 evicted by line 0", ncmd - n0, 1);
  endtask

  initial begin
    logic [287:0] d0, d1, d2, d3;
    int l0, l1, l2, l3, n0, last, p, first;
    for (int c = 0; c < 4; c++) begin
      rq_v[c] = 1'b0; rq_a[c] = '0; rs_r[c] = 1'b1;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      chk(rq_rdy[c] == 1'b1, "R1", "req_ready after reset", rq_rdy[c], 1);
      chk(rs_v[c] == 1'b0, "R1", "rsp_valid after reset", rs_v[c], 0);
    end
    chk(mem_cmd_valid == 1'b0, "R1", "mem_cmd_valid after reset", mem_cmd_valid, 0);

    for (int c = 0; c < 4; c++) sweep(c);

    // R9 / R10: four simultaneous misses
    last = log_addr[ncmd-1] >> (AW+3);
    n0 = ncmd;
    fork
      access(0, 200, 0, d0, l0);
      access(1, 400, 0, d1, l1);
      access(2, 200, 0, d2, l2);
      access(3, 401, 0, d3, l3);
    join
    chk(ncmd == n0 + 4, "R9", "four commands", ncmd - n0, 4);
    for (int k = 0; k < 4; k++)
      chk((log_addr[n0+k] >> (AW+3)) == (last + 1 + k) % 4, "R9", "grant order",
          log_addr[n0+k] >> (AW+3), (last + 1 + k) % 4);
    chk(d0 == expd(0, 200), "R10", "trv data after shared bursts", d0, expd(0, 200));
    chk(d1 == expd(1, 400), "R10", "lst data after shared bursts", d1, expd(1, 400));
    chk(d2 == expd(2, 200), "R10", "isc data after shared bursts", d2, expd(2, 200));
    chk(d3 == expd(3, 401), "R10", "shd data after shared bursts", d3, expd(3, 401));

    // R9: two waiting classes
    last = log_addr[ncmd-1] >> (AW+3);
    p = (last + 1) % 4;
    first = (((1 - p) & 3) < ((3 - p) & 3)) ? 1 : 3;
    n0 = ncmd;
    fork
      access(1, 600, 0, d1, l1);
      access(3, 600, 0, d3, l3);
    join
    chk((log_addr[n0] >> (AW+3)) == first, "R9", "pair grant order",
        log_addr[n0] >> (AW+3), first);
    chk(d1 == expd(1, 600) && d3 == expd(3, 600), "R9", "pair data", d1, expd(1, 600));

    // R11: back-pressure and hits during another class's miss
    fork
      access(2, 300, 0, d2, l2);
      begin
        repeat (3) @(negedge clk);
        access(0, 200, 3, d0, l0);
      end
      begin
        repeat (3) @(negedge clk);
        access(1, 401, 0, d1, l1);
      end
    join
    chk(l0 == 1, "R11", "trv hit during isc miss", l0, 1);
    chk(l1 == 1, "R11", "lst hit during isc miss", l1, 1);
    chk(d0 == expd(0, 200), "R11", "held trv data", d0, expd(0, 200));
    chk(d2 == expd(2, 300), "R4", "isc miss data", d2, expd(2, 300));

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule